// File: doc/BRIEF.md
# Display Identification Base Block Checker and Field Extractor

This block takes in the 128-byte base block of a display's identification data as it arrives over a byte stream. Each byte comes with a valid strobe and its position in the block. While the bytes stream past, the block does two jobs. It keeps a running modulo-256 sum and checks the fixed eight-byte preamble. It also keeps the few bytes that carry identity and first-timing information. When the last byte has been taken, it gives a one-cycle verdict. If the block passes, it loads a full set of decoded fields into its output registers.

The decoded fields are:
- the three-letter vendor code, the product number, version and revision, and the count of extension blocks;
- the digital interface type, the colour depth, the power-management code and the colour format;
- the first detailed timing descriptor, with its 12-bit and 10-bit quantities rebuilt from nibbles and bit pairs spread over several bytes.

A rejected block leaves every field output as it was. The two error flags tell a bad sum from a bad preamble. Bytes must be delivered in ascending position order, starting at position 0. Idle cycles may appear between bytes.

Top module: `edid_block_parser`

## Requirements
- R1: After a synchronous reset, `res_done`, `res_ok`, both error flags and every field output are 0.
- R2: `res_done` is high for exactly the one cycle that follows the clock edge at which position 127 is accepted with `in_valid` high. The status flags are loaded at that same edge and hold until the next verdict.
- R3: `res_err_sum` is 1 exactly when the 128 accepted bytes do not add up to 0 modulo 256.
- R4: `res_err_hdr` is 1 exactly when any byte at positions 0 to 7 differs from 0x00, 0xFF, 0xFF, 0xFF, 0xFF, 0xFF, 0xFF, 0x00 (in that position order). Both error flags may be set together. `res_ok` is 1 only when neither flag is set.
- R5: Each vendor letter is output as ASCII 0x40 plus a 5-bit code. Letter 1 takes bits 6:2 of byte 0x08. Letter 2 takes {byte 0x08 bits 1:0, byte 0x09 bits 7:5}. Letter 3 takes bits 4:0 of byte 0x09.
- R6: The product number is {byte 0x0B, byte 0x0A}. Version is byte 0x12, revision is byte 0x13, and the extension count is byte 0x7E.
- R7: `is_digital` is bit 7 of byte 0x14. When that bit is set, the interface type is bits 3:0 of byte 0x14, and the colour depth is 2n+4 with n = bits 6:4 (0 when n is 0). When that bit is clear, both the interface type and the colour depth are 0. `power_mgmt` is bits 7:5 of byte 0x18. `color_format` is bits 4:3 of byte 0x18 for a digital display, otherwise 0.
- R8: The pixel clock is {byte 0x37, byte 0x36}, in 10 kHz units. The descriptor is present unless the pixel clock and byte 0x38 are all zero. When it is absent, `dtd_present` and every timing output are 0.
- R9: Horizontal active is {0x3A[7:4], 0x38} and horizontal blank is {0x3A[3:0], 0x39}. Vertical active is {0x3D[7:4], 0x3B} and vertical blank is {0x3D[3:0], 0x3C}.
- R10: Horizontal front porch is {0x41[7:6], 0x3E} and horizontal sync is {0x41[5:4], 0x3F}. Vertical front porch is {0x41[3:2], 0x40[7:4]} and vertical sync is {0x41[1:0], 0x40[3:0]}.
- R11: Image width is {0x44[7:4], 0x42} mm and height is {0x44[3:0], 0x43} mm. The horizontal and vertical borders are bytes 0x45 and 0x46.
- R12: From byte 0x47:
  - interlaced = bit 7, stereo = bits 6:5, digital sync = bit 4;
  - separate sync = bit 4 AND bit 3;
  - vsync positive = separate AND bit 2;
  - hsync positive = separate AND bit 1.
- R13: An accepted block updates every field output at the verdict edge. A rejected block leaves every field output unchanged.
- R14: A cycle with `in_valid` low has no effect, even when `in_index` shows 127. Idle gaps between bytes do not change the verdict or the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_index | input | 7 | Position of the byte in the block |
| in_byte | input | 8 | Byte value |
| res_done | output | 1 | One-cycle verdict pulse |
| res_ok | output | 1 | Block accepted |
| res_err_sum | output | 1 | Sum of the block is not zero |
| res_err_hdr | output | 1 | Preamble mismatch |
| mfr_char1 | output | 8 | Vendor letter 1, ASCII |
| mfr_char2 | output | 8 | Vendor letter 2, ASCII |
| mfr_char3 | output | 8 | Vendor letter 3, ASCII |
| product_id | output | 16 | Product number |
| edid_version | output | 8 | Version |
| edid_revision | output | 8 | Revision |
| ext_blocks | output | 8 | Extension block count |
| is_digital | output | 1 | Digital input flag |
| video_iface | output | 4 | Digital interface type |
| color_bits | output | 5 | Bits per colour component |
| power_mgmt | output | 3 | Power-management code |
| color_format | output | 2 | Colour encoding code |
| dtd_present | output | 1 | First timing descriptor present |
| dtd_pclk_10k | output | 16 | Pixel clock, 10 kHz units |
| dtd_h_active | output | 12 | Horizontal active pixels |
| dtd_h_blank | output | 12 | Horizontal blanking |
| dtd_v_active | output | 12 | Vertical active lines |
| dtd_v_blank | output | 12 | Vertical blanking |
| dtd_h_porch | output | 10 | Horizontal front porch |
| dtd_h_sync | output | 10 | Horizontal sync width |
| dtd_v_porch | output | 6 | Vertical front porch |
| dtd_v_sync | output | 6 | Vertical sync width |
| dtd_width_mm | output | 12 | Image width in mm |
| dtd_height_mm | output | 12 | Image height in mm |
| dtd_h_border | output | 8 | Horizontal border |
| dtd_v_border | output | 8 | Vertical border |
| dtd_interlaced | output | 1 | Interlaced flag |
| dtd_stereo | output | 2 | Stereo mode |
| dtd_digital_sync | output | 1 | Digital sync flag |
| dtd_separate_sync | output | 1 | Digital separate sync |
| dtd_vsync_pos | output | 1 | Vertical sync positive |
| dtd_hsync_pos | output | 1 | Horizontal sync positive |

## Verification
The sum verdict and the field commit fall on the same clock edge. The last byte closes the running sum, and the result of that sum decides in that cycle whether the staged fields reach the outputs. The bench alternates accepted blocks with blocks that carry a bad sum, a bad preamble or both. It checks that the verdict flags are right and that a rejected block leaves the outputs equal to the fields computed for the last accepted block. Idle gaps that show position 127 with the strobe low are inserted as well, to show that a verdict fires only on a real last byte.

// File: rtl/edid_pkg.sv
package edid_pkg;

    localparam int EDID_LEN  = 128;
    localparam int HDR_LEN   = 8;
    localparam int DTD_BASE  = 'h36;
    localparam int DTD_LEN   = 18;

    localparam int ACT_W     = 12;
    localparam int PORCH_W   = 10;
    localparam int VPS_W     = 6;
    localparam int DEPTH_W   = 5;

    // staging slots: 0..17 hold the timing descriptor, the rest identity bytes
    localparam int S_MFR0  = DTD_LEN + 0;
    localparam int S_MFR1  = DTD_LEN + 1;
    localparam int S_PRODL = DTD_LEN + 2;
    localparam int S_PRODH = DTD_LEN + 3;
    localparam int S_VER   = DTD_LEN + 4;
    localparam int S_REV   = DTD_LEN + 5;
    localparam int S_VID   = DTD_LEN + 6;
    localparam int S_FEAT  = DTD_LEN + 7;
    localparam int S_EXT   = DTD_LEN + 8;
    localparam int N_CAP   = DTD_LEN + 9;

    typedef logic [N_CAP-1:0][7:0] cap_vec_t;

    typedef struct packed {
        logic [7:0]         l1;
        logic [7:0]         l2;
        logic [7:0]         l3;
        logic [15:0]        product;
        logic [7:0]         version;
        logic [7:0]         revision;
        logic [7:0]         ext_cnt;
        logic               digital;
        logic [3:0]         iface;
        logic [DEPTH_W-1:0] depth;
        logic [2:0]         pm;
        logic [1:0]         cfmt;
    } ident_t;

    typedef struct packed {
        logic               present;
        logic [15:0]        pclk;
        logic [ACT_W-1:0]   h_act;
        logic [ACT_W-1:0]   h_blk;
        logic [ACT_W-1:0]   v_act;
        logic [ACT_W-1:0]   v_blk;
        logic [PORCH_W-1:0] h_fp;
        logic [PORCH_W-1:0] h_sw;
        logic [VPS_W-1:0]   v_fp;
        logic [VPS_W-1:0]   v_sw;
        logic [ACT_W-1:0]   w_mm;
        logic [ACT_W-1:0]   h_mm;
        logic [7:0]         h_bord;
        logic [7:0]         v_bord;
        logic               intl;
        logic [1:0]         stereo;
        logic               dsync;
        logic               sep;
        logic               vpol;
        logic               hpol;
    } timing_t;

    function automatic int cap_offset(input int s);
        if (s < DTD_LEN) return DTD_BASE + s;
        case (s)
            S_MFR0:  return 'h08;
            S_MFR1:  return 'h09;
            S_PRODL: return 'h0A;
            S_PRODH: return 'h0B;
            S_VER:   return 'h12;
            S_REV:   return 'h13;
            S_VID:   return 'h14;
            S_FEAT:  return 'h18;
            default: return 'h7E;
        endcase
    endfunction

    function automatic logic [7:0] hdr_expect(input int pos);
        return (pos == 0 || pos == HDR_LEN - 1) ? 8'h00 : 8'hFF;
    endfunction

    function automatic logic [7:0] to_letter(input logic [4:0] code);
        return {3'b010, code};
    endfunction

    function automatic ident_t decode_ident(input cap_vec_t c);
        ident_t d;
        logic [2:0] n;
        d.l1       = to_letter(c[S_MFR0][6:2]);
        d.l2       = to_letter({c[S_MFR0][1:0], c[S_MFR1][7:5]});
        d.l3       = to_letter(c[S_MFR1][4:0]);
        d.product  = {c[S_PRODH], c[S_PRODL]};
        d.version  = c[S_VER];
        d.revision = c[S_REV];
        d.ext_cnt  = c[S_EXT];
        d.digital  = c[S_VID][7];
        n          = c[S_VID][6:4];
        d.iface    = d.digital ? c[S_VID][3:0] : 4'd0;
        d.depth    = (d.digital && n != 3'd0) ? DEPTH_W'({n, 1'b0}) + DEPTH_W'(4) : '0;
        d.pm       = c[S_FEAT][7:5];
        d.cfmt     = d.digital ? c[S_FEAT][4:3] : 2'd0;
        return d;
    endfunction

    function automatic timing_t decode_timing(input cap_vec_t c);
        timing_t t;
        logic [7:0] f;
        logic [7:0] lo2;
        t   = '0;
        f   = c[17];
        lo2 = c[11];
        if ({c[1], c[0]} != 16'd0 || c[2] != 8'd0) begin
            t.present = 1'b1;
            t.pclk    = {c[1], c[0]};
            t.h_act   = {c[4][7:4], c[2]};
            t.h_blk   = {c[4][3:0], c[3]};
            t.v_act   = {c[7][7:4], c[5]};
            t.v_blk   = {c[7][3:0], c[6]};
            t.h_fp    = {lo2[7:6], c[8]};
            t.h_sw    = {lo2[5:4], c[9]};
            t.v_fp    = {lo2[3:2], c[10][7:4]};
            t.v_sw    = {lo2[1:0], c[10][3:0]};
            t.w_mm    = {c[14][7:4], c[12]};
            t.h_mm    = {c[14][3:0], c[13]};
            t.h_bord  = c[15];
            t.v_bord  = c[16];
            t.intl    = f[7];
            t.stereo  = f[6:5];
            t.dsync   = f[4];
            t.sep     = f[4] & f[3];
            t.vpol    = f[4] & f[3] & f[2];
            t.hpol    = f[4] & f[3] & f[1];
        end
        return t;
    endfunction

endpackage

// File: rtl/edid_integrity_chk.sv
module edid_integrity_chk
    import edid_pkg::*;
#(
    parameter int BLOCK_BYTES = EDID_LEN,
    parameter int HDR_BYTES   = HDR_LEN,
    localparam int IDX_W      = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_index,
    input  logic [7:0]       in_byte,
    output logic             last_o,
    output logic             sum_bad_o,
    output logic             hdr_bad_o
);

    logic [7:0] sum_q;
    logic [7:0] sum_next;
    logic       hdr_q;
    logic       is_first;
    logic       in_hdr;
    logic       mism;

    always_comb begin
        is_first = (in_index == '0);
        in_hdr   = (in_index < IDX_W'(HDR_BYTES));
        mism     = (in_byte != hdr_expect(int'(in_index)));
        sum_next = is_first ? in_byte : (sum_q + in_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            hdr_q <= 1'b0;
        end else if (in_valid) begin
            sum_q <= sum_next;
            hdr_q <= (is_first ? 1'b0 : hdr_q) | (in_hdr & mism);
        end
    end

    assign last_o    = in_valid && (in_index == IDX_W'(BLOCK_BYTES - 1));
    assign sum_bad_o = (sum_next != 8'd0);
    assign hdr_bad_o = hdr_q;

    // R3: the running sum restarts from the first byte of a block
    assert_sum_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_index == '0) |=> (sum_q == $past(in_byte)));

    // R4: a non-zero leading byte marks the preamble as bad
    assert_hdr_lead_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_index == '0 && in_byte != 8'h00) |=> hdr_q);

    // R14: idle cycles leave the sum untouched
    assert_idle_keep_R14: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(sum_q));

endmodule

// File: rtl/edid_byte_capture.sv
module edid_byte_capture
    import edid_pkg::*;
#(
    parameter int BLOCK_BYTES = EDID_LEN,
    localparam int IDX_W      = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_index,
    input  logic [7:0]       in_byte,
    output cap_vec_t         cap_o
);

    logic [7:0] slot_q [N_CAP];

    for (genvar s = 0; s < N_CAP; s++) begin : g_slot
        localparam int OFS = cap_offset(s);
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[s] <= '0;
            else if (in_valid && in_index == IDX_W'(OFS))
                slot_q[s] <= in_byte;
        end
        assign cap_o[s] = slot_q[s];
    end

    // R6: the version byte is staged from its own position
    assert_stage_ver_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_index == IDX_W'(cap_offset(S_VER))) |=> (slot_q[S_VER] == $past(in_byte)));

endmodule

// File: rtl/edid_field_decode.sv
module edid_field_decode
    import edid_pkg::*;
(
    input  cap_vec_t cap_i,
    output ident_t   ident_o,
    output timing_t  timing_o
);

    always_comb begin
        ident_o  = decode_ident(cap_i);
        timing_o = decode_timing(cap_i);
    end

endmodule

// File: rtl/edid_block_parser.sv
module edid_block_parser
    import edid_pkg::*;
#(
    parameter int BLOCK_BYTES = EDID_LEN,
    localparam int IDX_W      = $clog2(BLOCK_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [IDX_W-1:0]   in_index,
    input  logic [7:0]         in_byte,
    output logic               res_done,
    output logic               res_ok,
    output logic               res_err_sum,
    output logic               res_err_hdr,
    output logic [7:0]         mfr_char1,
    output logic [7:0]         mfr_char2,
    output logic [7:0]         mfr_char3,
    output logic [15:0]        product_id,
    output logic [7:0]         edid_version,
    output logic [7:0]         edid_revision,
    output logic [7:0]         ext_blocks,
    output logic               is_digital,
    output logic [3:0]         video_iface,
    output logic [DEPTH_W-1:0] color_bits,
    output logic [2:0]         power_mgmt,
    output logic [1:0]         color_format,
    output logic               dtd_present,
    output logic [15:0]        dtd_pclk_10k,
    output logic [ACT_W-1:0]   dtd_h_active,
    output logic [ACT_W-1:0]   dtd_h_blank,
    output logic [ACT_W-1:0]   dtd_v_active,
    output logic [ACT_W-1:0]   dtd_v_blank,
    output logic [PORCH_W-1:0] dtd_h_porch,
    output logic [PORCH_W-1:0] dtd_h_sync,
    output logic [VPS_W-1:0]   dtd_v_porch,
    output logic [VPS_W-1:0]   dtd_v_sync,
    output logic [ACT_W-1:0]   dtd_width_mm,
    output logic [ACT_W-1:0]   dtd_height_mm,
    output logic [7:0]         dtd_h_border,
    output logic [7:0]         dtd_v_border,
    output logic               dtd_interlaced,
    output logic [1:0]         dtd_stereo,
    output logic               dtd_digital_sync,
    output logic               dtd_separate_sync,
    output logic               dtd_vsync_pos,
    output logic               dtd_hsync_pos
);

    logic     last_w, sum_bad_w, hdr_bad_w;
    cap_vec_t cap_w;
    ident_t   ident_d, ident_q;
    timing_t  timing_d, timing_q;
    logic     done_q, ok_q, sum_err_q, hdr_err_q;

    edid_integrity_chk #(.BLOCK_BYTES(BLOCK_BYTES), .HDR_BYTES(HDR_LEN)) u_chk (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index), .in_byte(in_byte),
        .last_o(last_w), .sum_bad_o(sum_bad_w), .hdr_bad_o(hdr_bad_w)
    );

    edid_byte_capture #(.BLOCK_BYTES(BLOCK_BYTES)) u_cap (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index), .in_byte(in_byte),
        .cap_o(cap_w)
    );

    edid_field_decode u_dec (
        .cap_i(cap_w), .ident_o(ident_d), .timing_o(timing_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            ok_q      <= 1'b0;
            sum_err_q <= 1'b0;
            hdr_err_q <= 1'b0;
            ident_q   <= '0;
            timing_q  <= '0;
        end else begin
            done_q <= last_w;
            if (last_w) begin
                sum_err_q <= sum_bad_w;
                hdr_err_q <= hdr_bad_w;
                ok_q      <= !(sum_bad_w || hdr_bad_w);
                if (!(sum_bad_w || hdr_bad_w)) begin
                    ident_q  <= ident_d;
                    timing_q <= timing_d;
                end
            end
        end
    end

    assign res_done          = done_q;
    assign res_ok            = ok_q;
    assign res_err_sum       = sum_err_q;
    assign res_err_hdr       = hdr_err_q;
    assign mfr_char1         = ident_q.l1;
    assign mfr_char2         = ident_q.l2;
    assign mfr_char3         = ident_q.l3;
    assign product_id        = ident_q.product;
    assign edid_version      = ident_q.version;
    assign edid_revision     = ident_q.revision;
    assign ext_blocks        = ident_q.ext_cnt;
    assign is_digital        = ident_q.digital;
    assign video_iface       = ident_q.iface;
    assign color_bits        = ident_q.depth;
    assign power_mgmt        = ident_q.pm;
    assign color_format      = ident_q.cfmt;
    assign dtd_present       = timing_q.present;
    assign dtd_pclk_10k      = timing_q.pclk;
    assign dtd_h_active      = timing_q.h_act;
    assign dtd_h_blank       = timing_q.h_blk;
    assign dtd_v_active      = timing_q.v_act;
    assign dtd_v_blank       = timing_q.v_blk;
    assign dtd_h_porch       = timing_q.h_fp;
    assign dtd_h_sync        = timing_q.h_sw;
    assign dtd_v_porch       = timing_q.v_fp;
    assign dtd_v_sync        = timing_q.v_sw;
    assign dtd_width_mm      = timing_q.w_mm;
    assign dtd_height_mm     = timing_q.h_mm;
    assign dtd_h_border      = timing_q.h_bord;
    assign dtd_v_border      = timing_q.v_bord;
    assign dtd_interlaced    = timing_q.intl;
    assign dtd_stereo        = timing_q.stereo;
    assign dtd_digital_sync  = timing_q.dsync;
    assign dtd_separate_sync = timing_q.sep;
    assign dtd_vsync_pos     = timing_q.vpol;
    assign dtd_hsync_pos     = timing_q.hpol;

    // R2: a verdict only follows an accepted final byte
    assert_done_from_last_R2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(in_valid && in_index == IDX_W'(BLOCK_BYTES - 1)));

    // R13: a rejected block leaves the field registers as they were
    assert_hold_on_reject_R13: assert property (@(posedge clk) disable iff (rst)
        (done_q && !ok_q) |-> ($stable(ident_q) && $stable(timing_q)));

    // R7: colour depth is zero or an even value from 6 to 18
    assert_depth_form_R7: assert property (@(posedge clk) disable iff (rst)
        (ident_q.depth == '0) || (!ident_q.depth[0] && ident_q.depth >= DEPTH_W'(6) && ident_q.depth <= DEPTH_W'(18)));

    // R5: letters are zero after reset or lie in the 0x40..0x5F range
    assert_letter_range_R5: assert property (@(posedge clk) disable iff (rst)
        (ident_q.l1 == 8'd0 || ident_q.l1[7:5] == 3'b010) && (ident_q.l3 == 8'd0 || ident_q.l3[7:5] == 3'b010));

    // R8: an absent descriptor reports a zero pixel clock and zero active size
    assert_absent_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !timing_q.present |-> (timing_q.pclk == 16'd0 && timing_q.h_act == '0 && timing_q.v_act == '0));

endmodule

// File: tb/edid_block_parser_tb_top.sv
`timescale 1ns/1ps
module edid_block_parser_tb_top;

    localparam int NF = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [6:0] in_index = '0;
    logic [7:0] in_byte = '0;

    logic res_done, res_ok, res_err_sum, res_err_hdr;
    logic [7:0] mfr_char1, mfr_char2, mfr_char3;
    logic [15:0] product_id;
    logic [7:0] edid_version, edid_revision, ext_blocks;
    logic is_digital;
    logic [3:0] video_iface;
    logic [4:0] color_bits;
    logic [2:0] power_mgmt;
    logic [1:0] color_format;
    logic dtd_present;
    logic [15:0] dtd_pclk_10k;
    logic [11:0] dtd_h_active, dtd_h_blank, dtd_v_active, dtd_v_blank;
    logic [9:0] dtd_h_porch, dtd_h_sync;
    logic [5:0] dtd_v_porch, dtd_v_sync;
    logic [11:0] dtd_width_mm, dtd_height_mm;
    logic [7:0] dtd_h_border, dtd_v_border;
    logic dtd_interlaced;
    logic [1:0] dtd_stereo;
    logic dtd_digital_sync, dtd_separate_sync, dtd_vsync_pos, dtd_hsync_pos;

    always #2 clk = ~clk;

    edid_block_parser dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index), .in_byte(in_byte),
        .res_done(res_done), .res_ok(res_ok), .res_err_sum(res_err_sum), .res_err_hdr(res_err_hdr),
        .mfr_char1(mfr_char1), .mfr_char2(mfr_char2), .mfr_char3(mfr_char3),
        .product_id(product_id), .edid_version(edid_version), .edid_revision(edid_revision),
        .ext_blocks(ext_blocks), .is_digital(is_digital), .video_iface(video_iface),
        .color_bits(color_bits), .power_mgmt(power_mgmt), .color_format(color_format),
        .dtd_present(dtd_present), .dtd_pclk_10k(dtd_pclk_10k),
        .dtd_h_active(dtd_h_active), .dtd_h_blank(dtd_h_blank),
        .dtd_v_active(dtd_v_active), .dtd_v_blank(dtd_v_blank),
        .dtd_h_porch(dtd_h_porch), .dtd_h_sync(dtd_h_sync),
        .dtd_v_porch(dtd_v_porch), .dtd_v_sync(dtd_v_sync),
        .dtd_width_mm(dtd_width_mm), .dtd_height_mm(dtd_height_mm),
        .dtd_h_border(dtd_h_border), .dtd_v_border(dtd_v_border),
        .dtd_interlaced(dtd_interlaced), .dtd_stereo(dtd_stereo),
        .dtd_digital_sync(dtd_digital_sync), .dtd_separate_sync(dtd_separate_sync),
        .dtd_vsync_pos(dtd_vsync_pos), .dtd_hsync_pos(dtd_hsync_pos)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int b [128];
    int nv [NF];
    int hv [NF];
    int gv [NF];
    string fname [NF];
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, got, exp);
        end
    endtask

    function automatic int next8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFF);
    endfunction

    task automatic snapshot();
        gv[0] = int'(mfr_char1);  gv[1] = int'(mfr_char2);  gv[2] = int'(mfr_char3);
        gv[3] = int'(product_id); gv[4] = int'(edid_version); gv[5] = int'(edid_revision);
        gv[6] = int'(ext_blocks); gv[7] = int'(is_digital); gv[8] = int'(video_iface);
        gv[9] = int'(color_bits); gv[10] = int'(power_mgmt); gv[11] = int'(color_format);
        gv[12] = int'(dtd_present); gv[13] = int'(dtd_pclk_10k);
        gv[14] = int'(dtd_h_active); gv[15] = int'(dtd_h_blank);
        gv[16] = int'(dtd_v_active); gv[17] = int'(dtd_v_blank);
        gv[18] = int'(dtd_h_porch); gv[19] = int'(dtd_h_sync);
        gv[20] = int'(dtd_v_porch); gv[21] = int'(dtd_v_sync);
        gv[22] = int'(dtd_width_mm); gv[23] = int'(dtd_height_mm);
        gv[24] = int'(dtd_h_border); gv[25] = int'(dtd_v_border);
        gv[26] = int'(dtd_interlaced); gv[27] = int'(dtd_stereo);
        gv[28] = int'(dtd_digital_sync); gv[29] = int'(dtd_separate_sync);
        gv[30] = int'(dtd_vsync_pos); gv[31] = int'(dtd_hsync_pos);
    endtask

    task automatic compare_fields(input string tag);
        snapshot();
        for (int k = 0; k < NF; k++) chk({tag, " ", fname[k]}, gv[k], hv[k]);
    endtask

    task automatic model();
        int dig, n, pc, f, sep;
        dig = (b[20] >> 7) & 1;
        n = (b[20] >> 4) & 7;
        nv[0] = 64 + ((b[8] >> 2) & 31);
        nv[1] = 64 + (((b[8] & 3) << 3) | (b[9] >> 5));
        nv[2] = 64 + (b[9] & 31);
        nv[3] = b[11] * 256 + b[10];
        nv[4] = b[18]; nv[5] = b[19]; nv[6] = b[126];
        nv[7] = dig;
        nv[8] = dig ? (b[20] & 15) : 0;
        nv[9] = (dig != 0 && n != 0) ? 2 * n + 4 : 0;
        nv[10] = b[24] >> 5;
        nv[11] = dig ? ((b[24] >> 3) & 3) : 0;
        pc = b[55] * 256 + b[54];
        for (int k = 12; k < NF; k++) nv[k] = 0;
        if (pc != 0 || b[56] != 0) begin
            f = b[71];
            sep = ((f >> 4) & 1) & ((f >> 3) & 1);
            nv[12] = 1; nv[13] = pc;
            nv[14] = (b[58] >> 4) * 256 + b[56];
            nv[15] = (b[58] & 15) * 256 + b[57];
            nv[16] = (b[61] >> 4) * 256 + b[59];
            nv[17] = (b[61] & 15) * 256 + b[60];
            nv[18] = (b[65] >> 6) * 256 + b[62];
            nv[19] = ((b[65] >> 4) & 3) * 256 + b[63];
            nv[20] = ((b[65] >> 2) & 3) * 16 + (b[64] >> 4);
            nv[21] = (b[65] & 3) * 16 + (b[64] & 15);
            nv[22] = (b[68] >> 4) * 256 + b[66];
            nv[23] = (b[68] & 15) * 256 + b[67];
            nv[24] = b[69]; nv[25] = b[70];
            nv[26] = f >> 7; nv[27] = (f >> 5) & 3; nv[28] = (f >> 4) & 1;
            nv[29] = sep; nv[30] = sep & ((f >> 2) & 1); nv[31] = sep & ((f >> 1) & 1);
        end
    endtask

    task automatic send_block(input bit stall);
        for (int i = 0; i < 128; i++) begin
            if (stall && (i % 17 == 5)) begin
                @(negedge clk);
                in_valid = 1'b0; in_index = 7'd127; in_byte = 8'hA5;
                @(negedge clk);
                chk("R14 idle slot showing last position", int'(res_done), 0);
                in_valid = 1'b1; in_index = 7'(i); in_byte = 8'(b[i]);
            end else begin
                @(negedge clk);
                in_valid = 1'b1; in_index = 7'(i); in_byte = 8'(b[i]);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_index = '0; in_byte = '0;
    endtask

    initial begin
        fname = '{"R5 letter1", "R5 letter2", "R5 letter3", "R6 product", "R6 version",
                  "R6 revision", "R6 ext_count", "R7 digital", "R7 iface", "R7 depth",
                  "R7 power_mgmt", "R7 color_format", "R8 present", "R8 pclk",
                  "R9 h_active", "R9 h_blank", "R9 v_active", "R9 v_blank",
                  "R10 h_porch", "R10 h_sync", "R10 v_porch", "R10 v_sync",
                  "R11 width_mm", "R11 height_mm", "R11 h_border", "R11 v_border",
                  "R12 interlaced", "R12 stereo", "R12 digital_sync", "R12 separate",
                  "R12 vsync_pos", "R12 hsync_pos"};
        for (int k = 0; k < NF; k++) hv[k] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset done", int'(res_done), 0);
        chk("R1 reset ok", int'(res_ok), 0);
        chk("R1 reset err_sum", int'(res_err_sum), 0);
        chk("R1 reset err_hdr", int'(res_err_hdr), 0);
        compare_fields("R1 reset");

        for (int blk = 0; blk < 48; blk++) begin
            int s, hb, cb, flip;
            for (int i = 8; i < 127; i++) b[i] = next8();
            b[20] = (b[20] & 8'h8F) | ((blk % 8) << 4);
            b[20] = (blk % 4 == 1) ? (b[20] & 127) : (b[20] | 128);
            b[71] = (b[71] & ~30) | ((blk % 16) << 1);
            if (blk % 6 == 2) begin b[54] = 0; b[55] = 0; b[56] = 0; end
            if (blk % 6 == 5) begin b[54] = 0; b[55] = 0; b[56] = b[56] | 1; end
            b[0] = 0; b[7] = 0;
            for (int i = 1; i < 7; i++) b[i] = 255;
            hb = (blk % 7 == 4) ? 1 : 0;
            if (hb != 0) begin
                flip = blk % 8;
                b[flip] = b[flip] ^ 90;
            end
            s = 0;
            for (int i = 0; i < 127; i++) s = s + b[i];
            b[127] = (256 - (s % 256)) % 256;
            cb = (blk % 5 == 3) ? 1 : 0;
            if (cb != 0) b[127] = (b[127] + 1 + blk) % 256;
            model();
            send_block(blk % 3 == 0);
            chk("R2 verdict pulse after last byte", int'(res_done), 1);
            chk("R3 sum error flag", int'(res_err_sum), cb);
            chk("R4 preamble error flag", int'(res_err_hdr), hb);
            chk("R4 ok flag", int'(res_ok), (cb == 0 && hb == 0) ? 1 : 0);
            if (cb == 0 && hb == 0) begin
                for (int k = 0; k < NF; k++) hv[k] = nv[k];
                compare_fields("R13 accepted");
            end else begin
                compare_fields("R13 rejected hold");
            end
            @(negedge clk);
            chk("R2 verdict lasts one cycle", int'(res_done), 0);
            chk("R2 flags held after verdict", int'(res_err_sum), cb);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule